// File: doc/BRIEF.md
# Framed Real-Time Parameter Broadcaster

This block sends a set of machine parameters over a serial link once per machine cycle. Software fills a register file of payload slots. Each slot holds a 24-bit payload and an enable bit. A cycle trigger starts a burst. The burst walks the enabled slots from the lowest index to the highest and sends one 40-bit frame per slot. Each frame is the slot number, the payload and a check byte. The burst finishes with a closing frame whose number is reserved. Its payload is a 24-bit checksum over every payload sent in that burst.

Slot contents are copied into a shadow set at the moment a burst starts. Software can therefore rewrite any slot while a burst is on the line, and the change appears in the next burst. Storage is built from banks of eight slots. The bit period is a whole number of clock cycles, so a 100 MHz clock gives a 10 Mbit/s line. Line coding, carrier generation and the host bus bridge sit outside this block.

Top module: `rtdl_broadcaster`

## Requirements
- R1: Every frame is 40 bits sent MSB first: an 8-bit frame number in bits 39:32, a 24-bit payload in bits 31:8 and an 8-bit check byte in bits 7:0. `tx_active` is high for the whole frame.
- R2: The check byte is a CRC-8 over the 32 bits of number and payload, MSB first. It uses polynomial 0x07 (x^8+x^2+x+1), starts from zero and has no final inversion.
- R3: Each bit stays on `tx_bit` for exactly CLK_DIV clock cycles, so `tx_active` stays high for exactly 40*CLK_DIV cycles per frame. `tx_bit` is low whenever `tx_active` is low.
- R4: Data frames are sent only for slots whose enable bit is 1, in strictly ascending slot order. The frame number of a data frame equals the slot index.
- R5: Each burst ends with one closing frame numbered 255. Its payload is a CRC-24 with polynomial 0x864CFB, seed zero and no final inversion, computed MSB first over the payloads of that burst's data frames in the order they were sent. The closing frame is sent even when no slot is enabled; its payload is then 0x000000.
- R6: Slot contents are captured at the trigger. A write made during a burst, or in the same cycle as the trigger, does not change that burst and does appear in the next one.
- R7: A trigger that arrives while `busy` is high does not restart or change the running burst. `overrun` is high for exactly the one cycle that follows such a trigger.
- R8: After reset, the block is idle with `tx_active`, `tx_bit`, `busy` and `overrun` low. All slots are disabled with zero payload.
- R9: A trigger while idle raises `busy` in the next cycle. `busy` falls in the same cycle that the closing frame leaves the line, and one trigger produces exactly one burst.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Slot write strobe |
| wr_slot | input | $clog2(NUM_FRAMES) | Slot index to write |
| wr_payload | input | 24 | Payload for the written slot |
| wr_enable | input | 1 | Enable bit for the written slot |
| cycle_trig | input | 1 | Machine-cycle trigger, one cycle wide |
| tx_bit | output | 1 | Serial data, MSB first |
| tx_active | output | 1 | High while a frame is on the line |
| busy | output | 1 | High while a burst is in progress |
| overrun | output | 1 | One-cycle pulse after a trigger that came while busy |

## Verification
A wrong slot cursor shows up within one frame time. It appears as a frame number that repeats, skips an enabled slot, goes backwards or names a disabled slot. A wrong checksum accumulator shows up only in the closing frame, so every burst's last frame is compared bit for bit. A faulty shadow capture leaves the wrong payload in the data frame of a rewritten slot. That error appears in the burst after the write or in the one in progress. A bit counter or divider fault changes the measured frame length on the very first frame after reset.

// File: rtl/rtdl_pkg.sv
package rtdl_pkg;

    localparam int FRAME_BITS = 40;
    localparam int DATA_W     = 24;
    localparam int NUM_W      = 8;
    localparam int BANK_SLOTS = 8;

    localparam logic [NUM_W-1:0]  CLOSE_NUM   = 8'hFF;
    localparam logic [7:0]        CRC8_POLY   = 8'h07;
    localparam logic [DATA_W-1:0] CRC24_POLY  = 24'h864CFB;
    localparam logic [DATA_W-1:0] CRC24_SEED  = 24'h000000;

    typedef struct packed {
        logic              en;
        logic [DATA_W-1:0] data;
    } slot_t;

    typedef struct packed {
        logic [NUM_W-1:0]  num;
        logic [DATA_W-1:0] data;
        logic [7:0]        chk;
    } frame_t;

    typedef enum logic [1:0] {
        SQ_IDLE,
        SQ_PICK,
        SQ_WAIT,
        SQ_LAST
    } seq_state_t;

    // CRC-8 over the 32 header+payload bits, MSB first, seed zero
    function automatic logic [7:0] crc8_hdr(input logic [31:0] bits);
        logic [7:0] c;
        logic       fb;
        c = 8'h00;
        for (int i = 31; i >= 0; i--) begin
            fb = c[7] ^ bits[i];
            c  = {c[6:0], 1'b0} ^ (fb ? CRC8_POLY : 8'h00);
        end
        return c;
    endfunction

    // Fold one 24-bit payload into the running burst checksum
    function automatic logic [DATA_W-1:0] crc24_step(input logic [DATA_W-1:0] acc,
                                                     input logic [DATA_W-1:0] d);
        logic [DATA_W-1:0] c;
        logic              fb;
        c = acc;
        for (int i = DATA_W - 1; i >= 0; i--) begin
            fb = c[DATA_W-1] ^ d[i];
            c  = {c[DATA_W-2:0], 1'b0} ^ (fb ? CRC24_POLY : '0);
        end
        return c;
    endfunction

    function automatic frame_t make_frame(input logic [NUM_W-1:0] num,
                                          input logic [DATA_W-1:0] d);
        frame_t f;
        f.num  = num;
        f.data = d;
        f.chk  = crc8_hdr({num, d});
        return f;
    endfunction

endpackage

// File: rtl/rtdl_bank.sv
module rtdl_bank
    import rtdl_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       wr_en,
    input  logic [2:0] wr_lo,
    input  slot_t      wr_slot,
    input  logic       snap,
    input  logic [2:0] rd_lo,
    output logic [BANK_SLOTS-1:0] snap_en,
    output slot_t      rd_slot
);

    slot_t live [BANK_SLOTS];
    slot_t held [BANK_SLOTS];
    logic [BANK_SLOTS*$bits(slot_t)-1:0] held_flat;

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < BANK_SLOTS; i++) begin
                live[i] <= '0;
                held[i] <= '0;
            end
        end else begin
            if (snap) begin
                for (int i = 0; i < BANK_SLOTS; i++) begin
                    held[i] <= live[i];
                end
            end
            if (wr_en) begin
                live[wr_lo] <= wr_slot;
            end
        end
    end

    always_comb begin
        for (int i = 0; i < BANK_SLOTS; i++) begin
            snap_en[i] = held[i].en;
            held_flat[i*$bits(slot_t) +: $bits(slot_t)] = held[i];
        end
        rd_slot = held[rd_lo];
    end

    AST_HELD_FROZEN: assert property (@(posedge clk) disable iff (rst)
        !snap |=> $stable(held_flat)); // R6

endmodule

// File: rtl/rtdl_next_slot.sv
module rtdl_next_slot #(
    parameter int N     = 16,
    parameter int IDX_W = 4
) (
    input  logic [N-1:0]     mask,
    input  logic [IDX_W-1:0] from_idx,
    input  logic             include_from,
    output logic             found,
    output logic [IDX_W-1:0] idx
);

    // Lowest enabled index above (or at, when include_from) from_idx
    always_comb begin
        found = 1'b0;
        idx   = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (mask[i] && ((i > int'(from_idx)) ||
                            (include_from && (i == int'(from_idx))))) begin
                found = 1'b1;
                idx   = IDX_W'(i);
            end
        end
    end

endmodule

// File: rtl/rtdl_shifter.sv
module rtdl_shifter
    import rtdl_pkg::*;
#(
    parameter int CLK_DIV = 10
) (
    input  logic   clk,
    input  logic   rst,
    input  logic   load,
    input  frame_t frame_in,
    output logic   tx_bit,
    output logic   active,
    output logic   last_tick
);

    localparam int DIV_W = $clog2(CLK_DIV + 1);
    localparam int CNT_W = $clog2(FRAME_BITS + 1);
    localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(FRAME_BITS - 1);

    logic [FRAME_BITS-1:0] sreg;
    logic [DIV_W-1:0]      div;
    logic [CNT_W-1:0]      bitn;
    logic                  tick;

    assign tick      = active && (div == DIV_W'(CLK_DIV - 1));
    assign last_tick = tick && (bitn == LAST_BIT);
    assign tx_bit    = active & sreg[FRAME_BITS-1];

    always_ff @(posedge clk) begin
        if (rst) begin
            sreg   <= '0;
            div    <= '0;
            bitn   <= '0;
            active <= 1'b0;
        end else if (load && !active) begin
            sreg   <= frame_in;
            div    <= '0;
            bitn   <= '0;
            active <= 1'b1;
        end else if (active) begin
            if (tick) begin
                div  <= '0;
                sreg <= {sreg[FRAME_BITS-2:0], 1'b0};
                bitn <= bitn + 1'b1;
                if (bitn == LAST_BIT) begin
                    active <= 1'b0;
                end
            end else begin
                div <= div + 1'b1;
            end
        end
    end

    AST_BIT_HOLD: assert property (@(posedge clk) disable iff (rst)
        (active && $past(active) && div != '0) |-> $stable(tx_bit)); // R3

    AST_FRAME_LEN: assert property (@(posedge clk) disable iff (rst)
        active |-> (bitn <= LAST_BIT)); // R3

endmodule

// File: rtl/rtdl_broadcaster.sv
module rtdl_broadcaster
    import rtdl_pkg::*;
#(
    parameter int NUM_FRAMES = 16,
    parameter int CLK_DIV    = 10
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          wr_en,
    input  logic [$clog2(NUM_FRAMES)-1:0] wr_slot,
    input  logic [23:0]                   wr_payload,
    input  logic                          wr_enable,
    input  logic                          cycle_trig,
    output logic                          tx_bit,
    output logic                          tx_active,
    output logic                          busy,
    output logic                          overrun
);

    localparam int IDX_W = $clog2(NUM_FRAMES);
    localparam int NBANK = NUM_FRAMES / BANK_SLOTS;

    seq_state_t        st;
    logic [IDX_W-1:0]  cur;
    logic              first;
    logic [DATA_W-1:0] acc;
    logic              ovr_q;

    logic              snap;
    logic [NUM_FRAMES-1:0] shadow_mask;
    slot_t             bank_rd [NBANK];
    slot_t             pk_slot;
    logic              pk_found;
    logic [IDX_W-1:0]  pk_idx;
    frame_t            frame_word;
    logic              ser_load;
    logic              ser_active;
    logic              ser_last;
    slot_t             wr_word;

    assign snap    = (st == SQ_IDLE) && cycle_trig;
    assign wr_word = '{en: wr_enable, data: wr_payload};

    for (genvar b = 0; b < NBANK; b++) begin : g_bank
        logic bank_wr;
        assign bank_wr = wr_en && ((wr_slot >> 3) == IDX_W'(b));

        rtdl_bank u_bank (
            .clk     (clk),
            .rst     (rst),
            .wr_en   (bank_wr),
            .wr_lo   (wr_slot[2:0]),
            .wr_slot (wr_word),
            .snap    (snap),
            .rd_lo   (pk_idx[2:0]),
            .snap_en (shadow_mask[b*BANK_SLOTS +: BANK_SLOTS]),
            .rd_slot (bank_rd[b])
        );
    end

    rtdl_next_slot #(
        .N     (NUM_FRAMES),
        .IDX_W (IDX_W)
    ) u_pick (
        .mask         (shadow_mask),
        .from_idx     (cur),
        .include_from (first),
        .found        (pk_found),
        .idx          (pk_idx)
    );

    always_comb begin
        pk_slot = '0;
        for (int b = 0; b < NBANK; b++) begin
            if ((pk_idx >> 3) == IDX_W'(b)) begin
                pk_slot = bank_rd[b];
            end
        end
    end

    always_comb begin
        if (pk_found) begin
            frame_word = make_frame(NUM_W'(pk_idx), pk_slot.data);
        end else begin
            frame_word = make_frame(CLOSE_NUM, acc);
        end
    end

    assign ser_load = (st == SQ_PICK);

    rtdl_shifter #(
        .CLK_DIV (CLK_DIV)
    ) u_ser (
        .clk       (clk),
        .rst       (rst),
        .load      (ser_load),
        .frame_in  (frame_word),
        .tx_bit    (tx_bit),
        .active    (ser_active),
        .last_tick (ser_last)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            st    <= SQ_IDLE;
            cur   <= '0;
            first <= 1'b1;
            acc   <= CRC24_SEED;
            ovr_q <= 1'b0;
        end else begin
            ovr_q <= cycle_trig && (st != SQ_IDLE);
            case (st)
                SQ_IDLE: begin
                    if (cycle_trig) begin
                        st    <= SQ_PICK;
                        cur   <= '0;
                        first <= 1'b1;
                        acc   <= CRC24_SEED;
                    end
                end
                SQ_PICK: begin
                    if (pk_found) begin
                        cur   <= pk_idx;
                        first <= 1'b0;
                        acc   <= crc24_step(acc, pk_slot.data);
                        st    <= SQ_WAIT;
                    end else begin
                        st <= SQ_LAST;
                    end
                end
                SQ_WAIT: begin
                    if (ser_last) begin
                        st <= SQ_PICK;
                    end
                end
                SQ_LAST: begin
                    if (ser_last) begin
                        st <= SQ_IDLE;
                    end
                end
                default: st <= SQ_IDLE;
            endcase
        end
    end

    assign tx_active = ser_active;
    assign busy      = (st != SQ_IDLE);
    assign overrun   = ovr_q;

    AST_LOAD_FREE: assert property (@(posedge clk) disable iff (rst)
        ser_load |-> !ser_active); // R1

    AST_SLOT_ASCEND: assert property (@(posedge clk) disable iff (rst)
        (st == SQ_PICK && pk_found && !first) |-> (pk_idx > cur)); // R4

    AST_PICK_ENABLED: assert property (@(posedge clk) disable iff (rst)
        (st == SQ_PICK && pk_found) |-> shadow_mask[pk_idx]); // R4

    AST_END_ON_FRAME: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> $past(ser_last)); // R9

endmodule

// File: tb/rtdl_broadcaster_tb.sv
module rtdl_broadcaster_tb;

    localparam int NF  = 16;
    localparam int DIV = 10;
    localparam int IW  = $clog2(NF);

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          wr_en = 1'b0;
    logic [IW-1:0] wr_slot = '0;
    logic [23:0]   wr_payload = '0;
    logic          wr_enable = 1'b0;
    logic          cycle_trig = 1'b0;
    logic          tx_bit, tx_active, busy, overrun;

    always #5 clk = ~clk;

    rtdl_broadcaster #(.NUM_FRAMES(NF), .CLK_DIV(DIV)) u_dut (
        .clk        (clk),
        .rst        (rst),
        .wr_en      (wr_en),
        .wr_slot    (wr_slot),
        .wr_payload (wr_payload),
        .wr_enable  (wr_enable),
        .cycle_trig (cycle_trig),
        .tx_bit     (tx_bit),
        .tx_active  (tx_active),
        .busy       (busy),
        .overrun    (overrun)
    );

    int checks = 0;
    int fails  = 0;

    logic [23:0] m_data [NF];
    logic        m_en   [NF];
    logic [39:0] exp_w  [NF+1];
    int          exp_n;
    logic [39:0] cap_w  [256];
    int          cap_n = 0;

    function automatic logic [7:0] b_crc8(input logic [31:0] v);
        logic [7:0] c = 8'h00;
        for (int i = 31; i >= 0; i--) begin
            if (c[7] ^ v[i]) c = {c[6:0], 1'b0} ^ 8'h07;
            else             c = {c[6:0], 1'b0};
        end
        return c;
    endfunction

    function automatic logic [23:0] b_crc24(input logic [23:0] a, input logic [23:0] v);
        logic [23:0] c = a;
        for (int i = 23; i >= 0; i--) begin
            if (c[23] ^ v[i]) c = {c[22:0], 1'b0} ^ 24'h864CFB;
            else              c = {c[22:0], 1'b0};
        end
        return c;
    endfunction

    function automatic logic [39:0] b_frame(input logic [7:0] n, input logic [23:0] d);
        return {n, d, b_crc8({n, d})};
    endfunction

    task automatic chk(input bit ok, input string req, input logic [63:0] act,
                       input logic [63:0] expv);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
        end
    endtask

    // Line monitor: rebuilds frames from mid-bit samples and times each frame
    int  mon_c = 0;
    logic [39:0] mon_w = '0;
    logic mon_prev = 1'b0;
    always @(negedge clk) begin
        if (tx_active) begin
            if (!mon_prev) begin
                mon_c = 0;
                mon_w = '0;
            end
            if ((mon_c % DIV) == DIV / 2) mon_w = {mon_w[38:0], tx_bit};
            mon_c++;
        end else begin
            if (mon_prev) begin
                chk(mon_c == 40 * DIV, "R3 frame length", 64'(mon_c), 64'(40 * DIV));
                if (cap_n < 256) cap_w[cap_n] = mon_w;
                cap_n++;
            end
            if (!rst && tx_bit) chk(1'b0, "R3 idle line", 64'(tx_bit), 64'd0);
        end
        mon_prev = tx_active;
    end

    task automatic write_slot(input int idx, input logic [23:0] d, input logic en);
        @(negedge clk);
        wr_en      = 1'b1;
        wr_slot    = IW'(idx);
        wr_payload = d;
        wr_enable  = en;
        m_data[idx] = d;
        m_en[idx]   = en;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic build_expected();
        logic [23:0] a = 24'h0;
        exp_n = 0;
        for (int i = 0; i < NF; i++) begin
            if (m_en[i]) begin
                exp_w[exp_n] = b_frame(8'(i), m_data[i]);
                a = b_crc24(a, m_data[i]);
                exp_n++;
            end
        end
        exp_w[exp_n] = b_frame(8'hFF, a);
        exp_n++;
    endtask

    int burst_start;

    task automatic start_burst();
        build_expected();
        burst_start = cap_n;
        @(negedge clk);
        cycle_trig = 1'b1;
        @(negedge clk);
        cycle_trig = 1'b0;
        chk(busy == 1'b1, "R9 busy after trigger", 64'(busy), 64'd1);
        chk(overrun == 1'b0, "R7 no overrun when idle", 64'(overrun), 64'd0);
    endtask

    task automatic finish_burst(input string tag);
        int got;
        while (busy) @(negedge clk);
        repeat (3) @(negedge clk);
        got = cap_n - burst_start;
        chk(got == exp_n, {tag, " R9 frame count"}, 64'(got), 64'(exp_n));
        for (int k = 0; k < exp_n && k < got; k++) begin
            if (k == exp_n - 1)
                chk(cap_w[burst_start + k] == exp_w[k], {tag, " R5 closing frame"},
                    64'(cap_w[burst_start + k]), 64'(exp_w[k]));
            else
                chk(cap_w[burst_start + k] == exp_w[k], {tag, " R1 R2 R4 data frame"},
                    64'(cap_w[burst_start + k]), 64'(exp_w[k]));
        end
        // one trigger gives one burst: line stays quiet afterwards
        repeat (60) @(negedge clk);
        chk(cap_n - burst_start == got, {tag, " R9 single burst"},
            64'(cap_n - burst_start), 64'(got));
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL R9 watchdog actual=hung expected=idle");
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        void'($urandom(32'h5EED_0042));
        for (int i = 0; i < NF; i++) begin
            m_data[i] = '0;
            m_en[i]   = 1'b0;
        end
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R8 reset state
        chk(!tx_active, "R8 tx_active after reset", 64'(tx_active), 64'd0);
        chk(!tx_bit,    "R8 tx_bit after reset",    64'(tx_bit),    64'd0);
        chk(!busy,      "R8 busy after reset",      64'(busy),      64'd0);
        chk(!overrun,   "R8 overrun after reset",   64'(overrun),   64'd0);

        // R5/R8: nothing written, only the closing frame with a zero checksum
        start_burst();
        finish_burst("empty");

        // random payloads, about half enabled, both end slots forced on (R4)
        for (int i = 0; i < NF; i++)
            write_slot(i, 24'($urandom), ((i == 0) || (i == NF - 1)) ? 1'b1 : 1'($urandom));

        // R6 and R7: writes and a second trigger while the burst runs
        start_burst();
        repeat (700) @(negedge clk);
        write_slot(0, 24'hA5A5A5, 1'b0);
        write_slot(5, 24'h123456, 1'b1);
        @(negedge clk);
        cycle_trig = 1'b1;
        @(negedge clk);
        cycle_trig = 1'b0;
        chk(overrun == 1'b1, "R7 overrun pulse", 64'(overrun), 64'd1);
        chk(busy == 1'b1, "R7 burst still running", 64'(busy), 64'd1);
        @(negedge clk);
        chk(overrun == 1'b0, "R7 overrun one cycle", 64'(overrun), 64'd0);
        finish_burst("snapshot R6");

        // next burst carries the mid-burst writes (R6)
        start_burst();
        finish_burst("after-write R6");

        // write coinciding with the trigger belongs to the next burst (R6)
        build_expected();
        burst_start = cap_n;
        @(negedge clk);
        cycle_trig = 1'b1;
        wr_en = 1'b1; wr_slot = IW'(3); wr_payload = 24'hC0FFEE; wr_enable = 1'b1;
        @(negedge clk);
        cycle_trig = 1'b0; wr_en = 1'b0;
        finish_burst("same-cycle R6");
        m_data[3] = 24'hC0FFEE;
        m_en[3]   = 1'b1;
        start_burst();
        finish_burst("same-cycle next R6");

        // every slot enabled (R4 full ascending walk)
        for (int i = 0; i < NF; i++) write_slot(i, 24'($urandom), 1'b1);
        start_burst();
        finish_burst("all-on");

        // random configurations
        for (int r = 0; r < 3; r++) begin
            for (int i = 0; i < NF; i++) write_slot(i, 24'($urandom), 1'($urandom));
            start_burst();
            finish_burst("random");
        end

        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

endmodule